// File: doc/BRIEF.md
# Interrupt Running-Priority Stack Tracker

This block keeps the priority bookkeeping of one processor's interrupt interface. Each time an interrupt is acknowledged, its 8-bit priority is pushed onto a stack of nested running priorities. Its preemption level, which is the priority shifted right by one, is marked in the active-priority bitmap of every group the interrupt belongs to. An end-of-interrupt pops the top of the stack and clears that level in the bitmaps the popped entry was tagged with. Software must end interrupts in the exact reverse order in which it acknowledged them. The block never searches the stack; it always pops the top.

The bottom of the stack is a fixed idle entry of priority 0xFF, so the running priority reads 0xFF when nothing is in service. A push that would overfill the stack, or a pop of an empty stack, leaves all state unchanged and pulses an error output. The block also holds the priority mask, the two group enables and the two binary points as plain state. From these it computes a combinational preemption check for a candidate interrupt offered by the selection logic, which lies outside this block.

Top module: `irq_rpri_tracker`

## Requirements
- R1: After reset, the running priority is 0xFF, the priority mask is 0x00, both 128-bit active bitmaps are zero, both binary points are 0, both group enables are 0, and the error and preemption outputs are 0.
- R2: An accepted acknowledge sets bit (priority >> 1) in the group 0 bitmap when ack_grp_i[0] is 1, and in the group 1 bitmap when ack_grp_i[1] is 1. Both bits may be set at once.
- R3: An acknowledge is accepted only while fewer than DEPTH-1 interrupts (15 by default) are in service. A further acknowledge changes no state and raises the error output.
- R4: An end-of-interrupt with no interrupt in service changes no state and raises the error output.
- R5: The running priority is the priority of the most recently accepted acknowledge that has not been ended, or 0xFF when none is in service. It changes on the clock edge that processes the event.
- R6: An end-of-interrupt removes the most recent entry. It clears bit (entry priority >> 1) only in the bitmaps the entry's acknowledge set, even when that level was also set by an older entry.
- R7: When acknowledge and end-of-interrupt arrive in the same cycle, the acknowledge is applied first and the end-of-interrupt then pops the resulting top entry.
- R8: mask_we_i loads the priority mask, grp_en_we_i loads the group enables (bit 0 for group 0, bit 1 for group 1), and bpr_we_i[g] loads binary point g. Each new value appears on its output after the next clock edge.
- R9: preempt_o is 1 exactly when the enable of the candidate's group is 1 (cand_grp_i = 0 selects group 0, 1 selects group 1), and the candidate priority is numerically below both the priority mask and the running priority. The output is combinational from the inputs and the current state.
- R10: err_o is a one-cycle pulse in the cycle after a rejected acknowledge or a rejected end-of-interrupt, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ack_i | input | 1 | Acknowledge pulse |
| ack_prio_i | input | 8 | Priority of the acknowledged interrupt |
| ack_grp_i | input | 2 | Group membership of the acknowledged interrupt (bit 0 group 0, bit 1 group 1) |
| eoi_i | input | 1 | End-of-interrupt pulse |
| mask_we_i | input | 1 | Priority mask write enable |
| mask_wdata_i | input | 8 | Priority mask write value |
| grp_en_we_i | input | 1 | Group enables write enable |
| grp_en_wdata_i | input | 2 | Group enables write value |
| bpr_we_i | input | 2 | Binary point write enables, one per group |
| bpr_wdata_i | input | 3 | Binary point write value |
| cand_prio_i | input | 8 | Candidate interrupt priority |
| cand_grp_i | input | 1 | Candidate interrupt group |
| run_prio_o | output | 8 | Current running priority |
| active_g0_o | output | 128 | Group 0 active-priority bitmap |
| active_g1_o | output | 128 | Group 1 active-priority bitmap |
| err_o | output | 1 | Overflow or underflow error pulse |
| preempt_o | output | 1 | Candidate may preempt |
| prio_mask_o | output | 8 | Priority mask |
| grp_en_o | output | 2 | Group enables |
| bpr0_o | output | 3 | Group 0 binary point |
| bpr1_o | output | 3 | Group 1 binary point |

## Verification
The hardest situation to reach is the full stack. Fifteen accepted acknowledges are needed to get there, and at that point an acknowledge and an end-of-interrupt arrive together: the acknowledge must be rejected while the pop still happens. The stimulus nests fifteen descending priorities, sends one more acknowledge to provoke the overflow, then issues the same-cycle pair at full depth. It also nests two entries at the same preemption level in different groups, so that the clearing done by each pop can be told apart.

// File: rtl/irq_rpri_pkg.sv
package irq_rpri_pkg;
  localparam int unsigned PRIO_W = 8;
  localparam int unsigned GRP_N  = 2;
  localparam int unsigned LVL_W  = PRIO_W - 1;
  localparam int unsigned NUM_LVL = 1 << LVL_W;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [GRP_N-1:0]  grp_mask_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  typedef struct packed {
    prio_t     prio;
    grp_mask_t tag;
  } stk_entry_t;

  localparam prio_t      IDLE_PRIO  = '1;
  localparam stk_entry_t IDLE_ENTRY = '{prio: IDLE_PRIO, tag: '0};
endpackage

// File: rtl/irq_rpri_rst_sync.sv
module irq_rpri_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/irq_rpri_stack.sv
module irq_rpri_stack
  import irq_rpri_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       ack_i,
  input  prio_t      ack_prio_i,
  input  grp_mask_t  ack_grp_i,
  input  logic       eoi_i,
  output prio_t      run_prio_o,
  output logic       push_ok_o,
  output logic       pop_ok_o,
  output lvl_t       pop_lvl_o,
  output grp_mask_t  pop_tag_o,
  output logic       err_o
);
  localparam int unsigned IDX_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q, idx_d, idx_a, wr_idx;
  logic             idx_en;
  logic             err_q, err_d;
  logic             push_ok, pop_ok;
  stk_entry_t       new_ent, top_a;
  stk_entry_t       ent [DEPTH];

  // Bottom entry is the idle sentinel; it has no storage and cannot change.
  assign ent[0] = IDLE_ENTRY;

  assign new_ent = '{prio: ack_prio_i, tag: ack_grp_i};
  assign wr_idx  = idx_q + 1'b1;

  // Acknowledge is applied first, then end-of-interrupt sees its result.
  always_comb begin
    push_ok = ack_i && (idx_q != TOP_IDX);
    idx_a   = push_ok ? wr_idx : idx_q;
    top_a   = push_ok ? new_ent : ent[idx_q];
    pop_ok  = eoi_i && (idx_a != '0);
    idx_d   = pop_ok ? (idx_a - 1'b1) : idx_a;
    idx_en  = push_ok || pop_ok;
    err_d   = (ack_i && !push_ok) || (eoi_i && !pop_ok);
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_ent
    stk_entry_t slot_q;
    logic       slot_we;
    assign slot_we = push_ok && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)      slot_q <= IDLE_ENTRY;
      else if (slot_we) slot_q <= new_ent;
    end
    assign ent[i] = slot_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  assign run_prio_o = ent[idx_q].prio;
  assign push_ok_o  = push_ok;
  assign pop_ok_o   = pop_ok;
  assign pop_lvl_o  = top_a.prio[PRIO_W-1:1];
  assign pop_tag_o  = top_a.tag;
  assign err_o      = err_q;
endmodule

// File: rtl/irq_rpri_active.sv
module irq_rpri_active
  import irq_rpri_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               set_i,
  input  lvl_t               set_lvl_i,
  input  logic               clr_i,
  input  lvl_t               clr_lvl_i,
  output logic [NUM_LVL-1:0] bits_o
);
  logic [NUM_LVL-1:0] bits_q, bits_d;
  logic               bits_en;

  // Set then clear, matching acknowledge-before-end ordering.
  always_comb begin
    bits_d = bits_q;
    if (set_i) bits_d[set_lvl_i] = 1'b1;
    if (clr_i) bits_d[clr_lvl_i] = 1'b0;
    bits_en = set_i || clr_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/irq_rpri_cfg.sv
module irq_rpri_cfg
  import irq_rpri_pkg::*;
#(
  parameter int unsigned BPR_W = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             mask_we_i,
  input  prio_t            mask_wdata_i,
  input  logic             grp_en_we_i,
  input  grp_mask_t        grp_en_wdata_i,
  input  logic [GRP_N-1:0] bpr_we_i,
  input  logic [BPR_W-1:0] bpr_wdata_i,
  output prio_t            mask_o,
  output grp_mask_t        grp_en_o,
  output logic [BPR_W-1:0] bpr_o [GRP_N]
);
  prio_t     mask_q;
  grp_mask_t grp_en_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      grp_en_q <= '0;
    end else begin
      if (mask_we_i)   mask_q   <= mask_wdata_i;
      if (grp_en_we_i) grp_en_q <= grp_en_wdata_i;
    end
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_bpr
    logic [BPR_W-1:0] bpr_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)          bpr_q <= '0;
      else if (bpr_we_i[g]) bpr_q <= bpr_wdata_i;
    end
    assign bpr_o[g] = bpr_q;
  end

  assign mask_o   = mask_q;
  assign grp_en_o = grp_en_q;
endmodule

// File: rtl/irq_rpri_tracker.sv
module irq_rpri_tracker
  import irq_rpri_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BPR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_i,
  input  logic [7:0]         ack_prio_i,
  input  logic [1:0]         ack_grp_i,
  input  logic               eoi_i,
  input  logic               mask_we_i,
  input  logic [7:0]         mask_wdata_i,
  input  logic               grp_en_we_i,
  input  logic [1:0]         grp_en_wdata_i,
  input  logic [1:0]         bpr_we_i,
  input  logic [BPR_W-1:0]   bpr_wdata_i,
  input  logic [7:0]         cand_prio_i,
  input  logic               cand_grp_i,
  output logic [7:0]         run_prio_o,
  output logic [127:0]       active_g0_o,
  output logic [127:0]       active_g1_o,
  output logic               err_o,
  output logic               preempt_o,
  output logic [7:0]         prio_mask_o,
  output logic [1:0]         grp_en_o,
  output logic [BPR_W-1:0]   bpr0_o,
  output logic [BPR_W-1:0]   bpr1_o
);
  logic               rst_n_sync;
  logic               push_ok, pop_ok;
  lvl_t               pop_lvl;
  grp_mask_t          pop_tag;
  prio_t              run_prio;
  prio_t              mask_q;
  grp_mask_t          grp_en_q;
  logic [BPR_W-1:0]   bpr_q [GRP_N];
  logic [NUM_LVL-1:0] act_bits [GRP_N];

  irq_rpri_rst_sync u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_n_sync)
  );

  irq_rpri_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_ni     (rst_n_sync),
    .ack_i      (ack_i),
    .ack_prio_i (ack_prio_i),
    .ack_grp_i  (ack_grp_i),
    .eoi_i      (eoi_i),
    .run_prio_o (run_prio),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .pop_lvl_o  (pop_lvl),
    .pop_tag_o  (pop_tag),
    .err_o      (err_o)
  );

  for (genvar g = 0; g < GRP_N; g++) begin : g_act
    irq_rpri_active u_act (
      .clk       (clk),
      .rst_ni    (rst_n_sync),
      .set_i     (push_ok && ack_grp_i[g]),
      .set_lvl_i (ack_prio_i[PRIO_W-1:1]),
      .clr_i     (pop_ok && pop_tag[g]),
      .clr_lvl_i (pop_lvl),
      .bits_o    (act_bits[g])
    );
  end

  irq_rpri_cfg #(.BPR_W(BPR_W)) u_cfg (
    .clk            (clk),
    .rst_ni         (rst_n_sync),
    .mask_we_i      (mask_we_i),
    .mask_wdata_i   (mask_wdata_i),
    .grp_en_we_i    (grp_en_we_i),
    .grp_en_wdata_i (grp_en_wdata_i),
    .bpr_we_i       (bpr_we_i),
    .bpr_wdata_i    (bpr_wdata_i),
    .mask_o         (mask_q),
    .grp_en_o       (grp_en_q),
    .bpr_o          (bpr_q)
  );

  // Candidate must be enabled and strictly more urgent than mask and running priority.
  always_comb begin
    preempt_o = grp_en_q[cand_grp_i]
             && (cand_prio_i < mask_q)
             && (cand_prio_i < run_prio);
  end

  assign run_prio_o  = run_prio;
  assign active_g0_o = act_bits[0];
  assign active_g1_o = act_bits[1];
  assign prio_mask_o = mask_q;
  assign grp_en_o    = grp_en_q;
  assign bpr0_o      = bpr_q[0];
  assign bpr1_o      = bpr_q[1];
endmodule

// File: rtl/irq_rpri_chk.sv
module irq_rpri_chk
  import irq_rpri_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input logic         clk,
  input logic         rst_ni,
  input logic         ack_i,
  input logic [7:0]   ack_prio_i,
  input logic [1:0]   ack_grp_i,
  input logic         eoi_i,
  input logic [7:0]   cand_prio_i,
  input logic [7:0]   run_prio_o,
  input logic [127:0] active_g0_o,
  input logic [127:0] active_g1_o,
  input logic         err_o,
  input logic         preempt_o,
  input logic [7:0]   prio_mask_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH) + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q, cnt_a;
  logic             acc_push;

  // Independent occupancy count of the stack.
  assign acc_push = ack_i && (cnt_q != FULL);
  assign cnt_a    = acc_push ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (eoi_i && (cnt_a != '0)) cnt_q <= cnt_a - 1'b1;
    else cnt_q <= cnt_a;
  end

  a_r2_set_g0: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && ack_grp_i[0] && !eoi_i && cnt_q != FULL) |=> active_g0_o[$past(ack_prio_i[7:1])]);

  a_r2_set_g1: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && ack_grp_i[1] && !eoi_i && cnt_q != FULL) |=> active_g1_o[$past(ack_prio_i[7:1])]);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && !eoi_i && cnt_q == FULL) |=> (err_o && $stable(run_prio_o)
                                          && $stable(active_g0_o) && $stable(active_g1_o)));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_ni)
    (eoi_i && !ack_i && cnt_q == '0) |=> (err_o && run_prio_o == 8'hFF));

  a_r5_push_top: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && !eoi_i && cnt_q != FULL) |=> (run_prio_o == $past(ack_prio_i)));

  a_r5_idle_when_empty: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q == '0) |-> (run_prio_o == 8'hFF));

  a_r7_pair_keeps_prio: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_i && eoi_i && cnt_q != FULL) |=> $stable(run_prio_o));

  a_r9_preempt_bound: assert property (@(posedge clk) disable iff (!rst_ni)
    preempt_o |-> ((cand_prio_i < prio_mask_o) && (cand_prio_i < run_prio_o)));

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rst_ni)
    err_o |-> $past(ack_i || eoi_i));
endmodule

bind irq_rpri_tracker irq_rpri_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_ni      (rst_n_sync),
  .ack_i       (ack_i),
  .ack_prio_i  (ack_prio_i),
  .ack_grp_i   (ack_grp_i),
  .eoi_i       (eoi_i),
  .cand_prio_i (cand_prio_i),
  .run_prio_o  (run_prio_o),
  .active_g0_o (active_g0_o),
  .active_g1_o (active_g1_o),
  .err_o       (err_o),
  .preempt_o   (preempt_o),
  .prio_mask_o (prio_mask_o)
);

// File: tb/tb_irq_rpri_tracker.sv
`timescale 1ns/1ps
module tb_irq_rpri_tracker;
  localparam int DEPTH = 16;
  localparam int BPR_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic ack_i, eoi_i, mask_we_i, grp_en_we_i, cand_grp_i;
  logic [7:0] ack_prio_i, mask_wdata_i, cand_prio_i;
  logic [1:0] ack_grp_i, grp_en_wdata_i, bpr_we_i;
  logic [BPR_W-1:0] bpr_wdata_i;
  logic [7:0] run_prio_o, prio_mask_o;
  logic [127:0] active_g0_o, active_g1_o;
  logic err_o, preempt_o;
  logic [1:0] grp_en_o;
  logic [BPR_W-1:0] bpr0_o, bpr1_o;

  always #4 clk = ~clk;

  irq_rpri_tracker #(.DEPTH(DEPTH), .BPR_W(BPR_W)) dut (.*);

  // Behavioural reference model
  int            m_prio[$];
  int            m_tag[$];
  logic [127:0]  m_act [2];
  logic [7:0]    m_mask;
  logic [1:0]    m_en;
  logic [BPR_W-1:0] m_bpr [2];
  logic          m_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual=%0h expected=%0h at %0t", tag, cur_req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_run();
    return (m_prio.size() > 0) ? 8'(m_prio[$]) : 8'hFF;
  endfunction

  function automatic logic exp_pre();
    return m_en[cand_grp_i] && (cand_prio_i < m_mask) && (cand_prio_i < exp_run());
  endfunction

  task automatic model_reset();
    m_prio.delete(); m_tag.delete();
    m_act[0] = '0; m_act[1] = '0;
    m_mask = '0; m_en = '0; m_bpr[0] = '0; m_bpr[1] = '0; m_err = 0;
  endtask

  task automatic model_step();
    m_err = 0;
    if (ack_i) begin
      if (m_prio.size() < DEPTH - 1) begin
        m_prio.push_back(int'(ack_prio_i));
        m_tag.push_back(int'(ack_grp_i));
        for (int g = 0; g < 2; g++) if (ack_grp_i[g]) m_act[g][ack_prio_i >> 1] = 1'b1;
      end else m_err = 1;
    end
    if (eoi_i) begin
      if (m_prio.size() > 0) begin
        int p; int t;
        p = m_prio.pop_back();
        t = m_tag.pop_back();
        for (int g = 0; g < 2; g++) if (t[g]) m_act[g][p >> 1] = 1'b0;
      end else m_err = 1;
    end
    if (mask_we_i) m_mask = mask_wdata_i;
    if (grp_en_we_i) m_en = grp_en_wdata_i;
    for (int g = 0; g < 2; g++) if (bpr_we_i[g]) m_bpr[g] = bpr_wdata_i;
  endtask

  task automatic compare_all();
    chk("R5 run_prio", 128'(run_prio_o), 128'(exp_run()));
    chk("R2/R6 active_g0", active_g0_o, m_act[0]);
    chk("R2/R6 active_g1", active_g1_o, m_act[1]);
    chk("R10 err", 128'(err_o), 128'(m_err));
    chk("R9 preempt", 128'(preempt_o), 128'(exp_pre()));
    chk("R8 mask", 128'(prio_mask_o), 128'(m_mask));
    chk("R8 grp_en", 128'(grp_en_o), 128'(m_en));
    chk("R8 bpr0", 128'(bpr0_o), 128'(m_bpr[0]));
    chk("R8 bpr1", 128'(bpr1_o), 128'(m_bpr[1]));
  endtask

  task automatic idle_inputs();
    ack_i = 0; eoi_i = 0; mask_we_i = 0; grp_en_we_i = 0; bpr_we_i = '0;
    ack_prio_i = '0; ack_grp_i = '0; mask_wdata_i = '0; grp_en_wdata_i = '0; bpr_wdata_i = '0;
  endtask

  // Inputs are set at a falling edge; one rising edge; compared at the next falling edge.
  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  task automatic do_ack(logic [7:0] p, logic [1:0] g);
    ack_i = 1; ack_prio_i = p; ack_grp_i = g; step();
  endtask

  task automatic do_eoi();
    eoi_i = 1; step();
  endtask

  task automatic do_pair(logic [7:0] p, logic [1:0] g);
    ack_i = 1; ack_prio_i = p; ack_grp_i = g; eoi_i = 1; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    cand_prio_i = 8'h00; cand_grp_i = 0;
    rst_n = 0;
    model_reset();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    cur_req = "R1";
    compare_all();
    step();

    // R2 / R5: nested acknowledges in group 0, group 1 and both
    cur_req = "R2";
    do_ack(8'h40, 2'b01);
    do_ack(8'h21, 2'b10);
    do_ack(8'h10, 2'b11);

    // R6: reverse-order ends
    cur_req = "R6";
    do_eoi(); do_eoi(); do_eoi();

    // R6: two entries at the same level (0x30/0x31) in different groups
    do_ack(8'h31, 2'b01);
    do_ack(8'h30, 2'b10);
    do_eoi();
    do_eoi();

    // R4: end with empty stack
    cur_req = "R4";
    do_eoi();
    step();

    // R3: fill to DEPTH-1, then overflow
    cur_req = "R3";
    for (int i = 0; i < DEPTH - 1; i++) do_ack(8'(8'hF0 - 8 * i), 2'(1 + (i % 3)));
    do_ack(8'h02, 2'b11);
    step();

    // R7: same-cycle pair at full depth: ack rejected, pop happens
    cur_req = "R7";
    do_pair(8'h01, 2'b01);
    do_pair(8'h05, 2'b10);
    for (int i = 0; i < DEPTH - 2; i++) do_eoi();
    // R7: pair at empty and at depth one
    do_pair(8'h44, 2'b01);
    do_ack(8'h60, 2'b01);
    do_pair(8'h61, 2'b10);
    do_eoi();

    // R8: configuration state
    cur_req = "R8";
    mask_we_i = 1; mask_wdata_i = 8'h80; step();
    grp_en_we_i = 1; grp_en_wdata_i = 2'b01; step();
    bpr_we_i = 2'b01; bpr_wdata_i = 3'd5; step();
    bpr_we_i = 2'b10; bpr_wdata_i = 3'd2; step();

    // R9: preemption under mask, running priority and group enable
    cur_req = "R9";
    cand_grp_i = 0; cand_prio_i = 8'h7F; step();
    cand_prio_i = 8'h80; step();
    cand_grp_i = 1; cand_prio_i = 8'h10; step();
    grp_en_we_i = 1; grp_en_wdata_i = 2'b11; step();
    do_ack(8'h20, 2'b10);
    cand_prio_i = 8'h20; step();
    cand_prio_i = 8'h1F; step();
    do_eoi();

    // R7 / R10: random mix
    cur_req = "R7";
    for (int i = 0; i < 400; i++) begin
      ack_i = ($urandom % 3) == 0;
      eoi_i = ($urandom % 3) == 0;
      ack_prio_i = 8'($urandom);
      ack_grp_i = 2'($urandom);
      cand_prio_i = 8'($urandom);
      cand_grp_i = 1'($urandom);
      if ((i % 50) == 0) begin mask_we_i = 1; mask_wdata_i = 8'($urandom); end
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule